// File: doc/BRIEF.md
# Translation Cache with Cached Region Verdict

This block is a small, fully associative cache of 4 KiB page translations for one hart. Each slot keeps the virtual page tag, the physical page number, the page permission bits (read, write, execute, user) and the verdict that the physical region and attribute checker gave for that page when it was filled. On a hit, the block returns the physical address and a fault code in the same cycle. When protection regions are at least one page in size, the stored verdict is reused and no further region check is needed. A region coarser than a page needs no special handling, because it is checked once by the walker before the refill.

When the platform sets the fine-granularity flag, protection regions may be smaller than a page. The stored verdict is then never used. A translation hit still returns the physical address, but it raises a "region check required" indication so that the access goes through the full external check, as a miss would. The external walker writes entries through a valid/ready refill port that takes one entry per cycle. The port is back-pressured (ready low) only in a cycle in which a flush is requested. A refill that is held then must stay valid until ready returns. The walker must split a large page into 4 KiB entries, and each of those entries lies inside a single attribute region. A flush either clears every slot or clears the one slot that holds a given page. Software issues the full flush after it rewrites the protection registers.

Top module: `xlat_cache`

## Requirements
- R1: After reset no slot is valid. Every lookup misses: lk_hit=0, lk_paddr=0, lk_fault=0. rf_ready is 1.
- R2: A lookup with lk_valid=1 whose page number (vaddr[31:12]) matches a valid slot gives lk_hit=1 in the same cycle, with lk_paddr = {stored page frame, vaddr[11:0]}. A lookup that misses, or an idle port, gives lk_hit=0, lk_paddr=0 and lk_fault=0.
- R3: A refill is taken on a clock edge where rf_valid and rf_ready are both 1. rf_ready is 0 exactly in the cycles where fl_req is 1. A taken entry can be looked up from the next cycle. A lookup in the same cycle as the refill sees the contents from before the refill.
- R4: A taken refill is placed by this priority. First, a valid slot that already holds the same page is overwritten. Otherwise, the lowest-indexed invalid slot is used. Otherwise, the slot named by a round-robin pointer is used. The pointer is 0 after reset and advances by one (modulo 8) only on this last kind of placement.
- R5: On a hit, lk_fault=1 (page fault) in any of these cases: the access type lacks its page bit (type 0 load needs R, type 1 store needs W, type 2 fetch needs X, type 3 always faults); a user access (lk_user=1) targets a page without U; a supervisor fetch targets a page with U. Page permission bits are rf_pte_perm[0]=R, [1]=W, [2]=X, [3]=U.
- R6: On a hit with no page fault and fine_rgn=0, lk_fault=2 (region fault) when the cached region bit for the access type is 0. Region bits are rf_rgn_perm[0]=read, [1]=write, [2]=execute. Otherwise lk_fault=0.
- R7: lk_rgn_chk=1 exactly when lk_hit=1 and fine_rgn=1. In that case lk_fault is never 2, and the address and page faults are still reported. The fine flag does not change the stored region bits, so region faults return when the flag is cleared.
- R8: fl_req=1 with fl_by_addr=0 invalidates every slot on that edge.
- R9: fl_req=1 with fl_by_addr=1 invalidates only a slot whose page equals fl_vpn. Other slots keep hitting.
- R10: A lookup in a cycle with fl_req=1 reports a miss: lk_hit=0, lk_rgn_chk=0, lk_fault=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_acc | input | 2 | Access type: 0 load, 1 store, 2 fetch |
| lk_user | input | 1 | 1 for a user-level access, 0 for supervisor |
| lk_hit | output | 1 | Translation found |
| lk_rgn_chk | output | 1 | Hit, but region verdict must be checked externally |
| lk_paddr | output | 34 | Physical address on a hit, else 0 |
| lk_fault | output | 2 | 0 none, 1 page fault, 2 region fault |
| rf_valid | input | 1 | Refill entry offered |
| rf_ready | output | 1 | Refill can be taken this cycle |
| rf_vpn | input | 20 | Virtual page of the refill |
| rf_ppn | input | 22 | Physical page frame of the refill |
| rf_pte_perm | input | 4 | Page bits R, W, X, U (bits 0..3) |
| rf_rgn_perm | input | 3 | Region verdict read, write, execute (bits 0..2) |
| fine_rgn | input | 1 | Regions may be finer than a page |
| fl_req | input | 1 | Flush request |
| fl_by_addr | input | 1 | 1 flushes one page, 0 flushes all |
| fl_vpn | input | 20 | Page to flush when fl_by_addr=1 |

## Verification
A flush can land in the same cycle as either a lookup or a refill, and these collisions are the centre of the bench. The stimulus raises fl_req while a lookup of a resident page is active. The reference model expects a miss in that cycle and misses on later cycles, which covers both R8 and R10. The stimulus also holds rf_valid high during a flush. The model expects rf_ready low and no slot written, and a later lookup of that page must miss. A refill offered together with a lookup of the same page is judged as a miss in that cycle and a hit one cycle later.

// File: rtl/xc_pkg.sv
package xc_pkg;
  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2
  } acc_e;

  typedef enum logic [1:0] {
    FLT_NONE   = 2'd0,
    FLT_PAGE   = 2'd1,
    FLT_REGION = 2'd2
  } flt_e;

  localparam int PTE_W = 4;
  localparam int RGN_W = 3;
  localparam int PB_R  = 0;
  localparam int PB_W  = 1;
  localparam int PB_X  = 2;
  localparam int PB_U  = 3;
endpackage

// File: rtl/xc_entry.sv
module xc_entry import xc_pkg::*; #(
  parameter int VPN_W = 20,
  parameter int PPN_W = 22
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [VPN_W-1:0] wr_vpn,
  input  logic [PPN_W-1:0] wr_ppn,
  input  logic [PTE_W-1:0] wr_pte,
  input  logic [RGN_W-1:0] wr_rgn,
  input  logic             kill,
  input  logic [VPN_W-1:0] lk_vpn,
  input  logic [VPN_W-1:0] fl_vpn,
  output logic             vld_o,
  output logic [VPN_W-1:0] vpn_o,
  output logic [PPN_W-1:0] ppn_o,
  output logic [PTE_W-1:0] pte_o,
  output logic [RGN_W-1:0] rgn_o,
  output logic             lk_m,
  output logic             fl_m,
  output logic             rf_m
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_o <= 1'b0;
      vpn_o <= '0;
      ppn_o <= '0;
      pte_o <= '0;
      rgn_o <= '0;
    end else if (wr_en) begin
      vld_o <= 1'b1;
      vpn_o <= wr_vpn;
      ppn_o <= wr_ppn;
      pte_o <= wr_pte;
      rgn_o <= wr_rgn;
    end else if (kill) begin
      vld_o <= 1'b0;
    end
  end

  assign lk_m = vld_o && (vpn_o == lk_vpn);
  assign fl_m = vld_o && (vpn_o == fl_vpn);
  assign rf_m = vld_o && (vpn_o == wr_vpn);
endmodule

// File: rtl/xc_victim_sel.sv
module xc_victim_sel #(
  parameter int N = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
)(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         fire,
  input  logic [N-1:0] vld,
  input  logic [N-1:0] dup,
  output logic [N-1:0] wsel
);
  logic [IW-1:0] rr_q;
  logic [IW-1:0] free_idx;
  logic          all_full;
  logic          evict;

  assign all_full = &vld;
  assign evict    = fire && !(|dup) && all_full;

  always_comb begin
    free_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!vld[i]) free_idx = IW'(i);
    end
  end

  always_comb begin
    if (|dup)          wsel = dup;
    else if (!all_full) wsel = N'(1) << free_idx;
    else               wsel = N'(1) << rr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rr_q <= '0;
    else if (evict) rr_q <= (rr_q == IW'(N - 1)) ? '0 : rr_q + 1'b1;
  end

  p_wsel_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> $onehot(wsel));

  p_rr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    evict |=> rr_q == (($past(rr_q) == IW'(N - 1)) ? '0 : $past(rr_q) + 1'b1));
endmodule

// File: rtl/xc_perm_check.sv
module xc_perm_check import xc_pkg::*; (
  input  logic             hit,
  input  logic [1:0]       acc,
  input  logic             user,
  input  logic [PTE_W-1:0] pte,
  input  logic [RGN_W-1:0] rgn,
  input  logic             fine,
  output logic [1:0]       fault
);
  acc_e a;
  logic pte_ok, rgn_ok, priv_ok;

  always_comb begin
    a = acc_e'(acc);
    pte_ok = 1'b0;
    rgn_ok = 1'b0;
    case (a)
      ACC_LOAD:  begin pte_ok = pte[PB_R]; rgn_ok = rgn[0]; end
      ACC_STORE: begin pte_ok = pte[PB_W]; rgn_ok = rgn[1]; end
      ACC_FETCH: begin pte_ok = pte[PB_X]; rgn_ok = rgn[2]; end
      default:   begin pte_ok = 1'b0;      rgn_ok = 1'b0;   end
    endcase
    priv_ok = user ? pte[PB_U] : !(pte[PB_U] && (a == ACC_FETCH));
    if (!hit)                    fault = FLT_NONE;
    else if (!(pte_ok && priv_ok)) fault = FLT_PAGE;
    else if (!fine && !rgn_ok)   fault = FLT_REGION;
    else                         fault = FLT_NONE;
  end
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache import xc_pkg::*; #(
  parameter int VA_W    = 32,
  parameter int PA_W    = 34,
  parameter int OFF_W   = 12,
  parameter int ENTRIES = 8,
  localparam int VPN_W  = VA_W - OFF_W,
  localparam int PPN_W  = PA_W - OFF_W
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid,
  input  logic [VA_W-1:0]  lk_vaddr,
  input  logic [1:0]       lk_acc,
  input  logic             lk_user,
  output logic             lk_hit,
  output logic             lk_rgn_chk,
  output logic [PA_W-1:0]  lk_paddr,
  output logic [1:0]       lk_fault,
  input  logic             rf_valid,
  output logic             rf_ready,
  input  logic [VPN_W-1:0] rf_vpn,
  input  logic [PPN_W-1:0] rf_ppn,
  input  logic [PTE_W-1:0] rf_pte_perm,
  input  logic [RGN_W-1:0] rf_rgn_perm,
  input  logic             fine_rgn,
  input  logic             fl_req,
  input  logic             fl_by_addr,
  input  logic [VPN_W-1:0] fl_vpn
);
  logic [VPN_W-1:0] lk_vpn;
  logic [ENTRIES-1:0] vld, lk_m, fl_m, rf_m, wsel;
  logic [VPN_W-1:0] vpn_q [ENTRIES];
  logic [PPN_W-1:0] ppn_q [ENTRIES];
  logic [PTE_W-1:0] pte_q [ENTRIES];
  logic [RGN_W-1:0] rgn_q [ENTRIES];
  logic rf_fire, hit_any;
  logic [PPN_W-1:0] sel_ppn;
  logic [PTE_W-1:0] sel_pte;
  logic [RGN_W-1:0] sel_rgn;

  assign lk_vpn   = lk_vaddr[VA_W-1:OFF_W];
  assign rf_ready = !fl_req;
  assign rf_fire  = rf_valid && rf_ready;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    xc_entry #(.VPN_W(VPN_W), .PPN_W(PPN_W)) u_ent (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (rf_fire && wsel[g]),
      .wr_vpn (rf_vpn),
      .wr_ppn (rf_ppn),
      .wr_pte (rf_pte_perm),
      .wr_rgn (rf_rgn_perm),
      .kill   (fl_req && (!fl_by_addr || fl_m[g])),
      .lk_vpn (lk_vpn),
      .fl_vpn (fl_vpn),
      .vld_o  (vld[g]),
      .vpn_o  (vpn_q[g]),
      .ppn_o  (ppn_q[g]),
      .pte_o  (pte_q[g]),
      .rgn_o  (rgn_q[g]),
      .lk_m   (lk_m[g]),
      .fl_m   (fl_m[g]),
      .rf_m   (rf_m[g])
    );
  end

  xc_victim_sel #(.N(ENTRIES)) u_victim (
    .clk   (clk),
    .rst_n (rst_n),
    .fire  (rf_fire),
    .vld   (vld),
    .dup   (rf_m),
    .wsel  (wsel)
  );

  always_comb begin
    sel_ppn = '0;
    sel_pte = '0;
    sel_rgn = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lk_m[i]) begin
        sel_ppn = sel_ppn | ppn_q[i];
        sel_pte = sel_pte | pte_q[i];
        sel_rgn = sel_rgn | rgn_q[i];
      end
    end
  end

  assign hit_any    = lk_valid && !fl_req && (|lk_m);
  assign lk_hit     = hit_any;
  assign lk_rgn_chk = hit_any && fine_rgn;
  assign lk_paddr   = hit_any ? {sel_ppn, lk_vaddr[OFF_W-1:0]} : '0;

  xc_perm_check u_perm (
    .hit   (hit_any),
    .acc   (lk_acc),
    .user  (lk_user),
    .pte   (sel_pte),
    .rgn   (sel_rgn),
    .fine  (fine_rgn),
    .fault (lk_fault)
  );

  // checker state: last taken refill must be resident one cycle later
  logic             chk_fire;
  logic [VPN_W-1:0] chk_vpn;
  logic             chk_landed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_fire <= 1'b0;
      chk_vpn  <= '0;
    end else begin
      chk_fire <= rf_fire;
      chk_vpn  <= rf_vpn;
    end
  end
  always_comb begin
    chk_landed = 1'b0;
    for (int i = 0; i < ENTRIES; i++)
      if (vld[i] && vpn_q[i] == chk_vpn) chk_landed = 1'b1;
  end

  p_fill_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
    chk_fire |-> chk_landed);

  p_one_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_m));

  p_flush_all_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_req && !fl_by_addr) |=> (vld == '0));

  p_fault_needs_hit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_fault != 2'd0) |-> lk_hit);
endmodule

// File: tb/xlat_cache_tb.sv
module xlat_cache_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_vaddr = '0;
  logic [1:0]  lk_acc = '0;
  logic        lk_user = 1'b0;
  logic        lk_hit, lk_rgn_chk, rf_ready;
  logic [33:0] lk_paddr;
  logic [1:0]  lk_fault;
  logic        rf_valid = 1'b0;
  logic [19:0] rf_vpn = '0;
  logic [21:0] rf_ppn = '0;
  logic [3:0]  rf_pte_perm = '0;
  logic [2:0]  rf_rgn_perm = '0;
  logic        fine_rgn = 1'b0;
  logic        fl_req = 1'b0;
  logic        fl_by_addr = 1'b0;
  logic [19:0] fl_vpn = '0;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  string phase = "R1";

  always #10 clk = ~clk;

  xlat_cache u_dut (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_acc(lk_acc), .lk_user(lk_user),
    .lk_hit(lk_hit), .lk_rgn_chk(lk_rgn_chk), .lk_paddr(lk_paddr), .lk_fault(lk_fault),
    .rf_valid(rf_valid), .rf_ready(rf_ready), .rf_vpn(rf_vpn), .rf_ppn(rf_ppn),
    .rf_pte_perm(rf_pte_perm), .rf_rgn_perm(rf_rgn_perm),
    .fine_rgn(fine_rgn), .fl_req(fl_req), .fl_by_addr(fl_by_addr), .fl_vpn(fl_vpn)
  );

  // behavioural reference model
  bit          m_vld [8];
  logic [19:0] m_vpn [8];
  logic [21:0] m_ppn [8];
  logic [3:0]  m_pte [8];
  logic [2:0]  m_rgn [8];
  int          m_rr;

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_vld[i]) m_vld[i] = 0;
      m_rr = 0;
    end else if (fl_req) begin
      foreach (m_vld[i])
        if (!fl_by_addr || m_vpn[i] == fl_vpn) m_vld[i] = 0;
    end else if (rf_valid) begin
      int slot;
      slot = -1;
      foreach (m_vld[i]) if (slot < 0 && m_vld[i] && m_vpn[i] == rf_vpn) slot = i;
      if (slot < 0) foreach (m_vld[i]) if (slot < 0 && !m_vld[i]) slot = i;
      if (slot < 0) begin
        slot = m_rr;
        m_rr = (m_rr + 1) % 8;
      end
      m_vld[slot] = 1;
      m_vpn[slot] = rf_vpn;
      m_ppn[slot] = rf_ppn;
      m_pte[slot] = rf_pte_perm;
      m_rgn[slot] = rf_rgn_perm;
    end
  end

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s phase=%s t=%0t actual=%h expected=%h", tag, phase, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      bit e_hit;
      logic [33:0] e_pa;
      logic [1:0]  e_flt;
      logic [3:0]  p;
      logic [2:0]  r;
      bit need, rneed;
      e_hit = 0; e_pa = '0; e_flt = 2'd0; p = '0; r = '0;
      if (lk_valid && !fl_req)
        foreach (m_vld[i])
          if (m_vld[i] && m_vpn[i] == lk_vaddr[31:12]) begin
            e_hit = 1; p = m_pte[i]; r = m_rgn[i];
            e_pa = {m_ppn[i], lk_vaddr[11:0]};
          end
      if (e_hit) begin
        need = (lk_acc == 2'd0) ? p[0] : (lk_acc == 2'd1) ? p[1] : (lk_acc == 2'd2) ? p[2] : 1'b0;
        rneed = (lk_acc == 2'd0) ? r[0] : (lk_acc == 2'd1) ? r[1] : r[2];
        if (lk_user && !p[3]) need = 0;
        if (!lk_user && p[3] && lk_acc == 2'd2) need = 0;
        if (!need) e_flt = 2'd1;
        else if (!fine_rgn && !rneed) e_flt = 2'd2;
      end
      check(fl_req ? "R10" : "R2", 64'(lk_hit), 64'(e_hit));
      check("R2", 64'(lk_paddr), 64'(e_pa));
      check(fine_rgn ? "R7" : "R5 R6", 64'(lk_fault), 64'(e_flt));
      check("R7", 64'(lk_rgn_chk), 64'(e_hit && fine_rgn));
      check("R3", 64'(rf_ready), 64'(!fl_req));
    end
  end

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic look(logic [31:0] va, logic [1:0] acc, logic usr);
    lk_valid = 1; lk_vaddr = va; lk_acc = acc; lk_user = usr;
    step();
    lk_valid = 0;
  endtask

  task automatic fill(logic [19:0] vpn, logic [21:0] ppn, logic [3:0] pte, logic [2:0] rgn);
    rf_valid = 1; rf_vpn = vpn; rf_ppn = ppn; rf_pte_perm = pte; rf_rgn_perm = rgn;
    step();
    rf_valid = 0;
  endtask

  task automatic flush(logic by_addr, logic [19:0] vpn);
    fl_req = 1; fl_by_addr = by_addr; fl_vpn = vpn;
    step();
    fl_req = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    // R1: empty after reset
    look(32'h1234_5678, 2'd0, 1'b0);
    look(32'h0000_0000, 2'd2, 1'b1);

    // R3: refill with lookup of same page in the same cycle
    phase = "R3";
    lk_valid = 1; lk_vaddr = 32'h0004_2abc; lk_acc = 2'd0; lk_user = 0;
    fill(20'h00042, 22'h3_0042, 4'b0111, 3'b111);
    look(32'h0004_2abc, 2'd0, 1'b0);

    // R2: fill all slots, look up with varied offsets
    phase = "R2";
    for (int i = 1; i < 8; i++)
      fill(20'h00100 + 20'(i), 22'h2_0000 + 22'(i * 3), 4'b0111, 3'b111);
    for (int i = 0; i < 8; i++) look({20'h00100 + 20'(i), 12'(i * 300)}, 2'(i % 3), 1'b0);
    look(32'h0004_2fff, 2'd1, 1'b0);

    // R4: round-robin eviction, duplicate overwrite, refill of freed slot
    phase = "R4";
    for (int i = 0; i < 20; i++) begin
      fill(20'h00300 + 20'(i), 22'h1_0000 + 22'(i), 4'b1111, 3'b011);
      look({20'h00300 + 20'(i), 12'h010}, 2'd0, 1'b1);
      look({20'h00300 + 20'(i > 8 ? i - 8 : 0), 12'h020}, 2'd0, 1'b1);
    end
    fill(20'h00310, 22'h3_ffff, 4'b0011, 3'b001);
    look(32'h0031_0444, 2'd0, 1'b0);
    flush(1'b1, 20'h0030f);
    fill(20'h00555, 22'h0_0555, 4'b0111, 3'b111);
    fill(20'h00556, 22'h0_0556, 4'b0111, 3'b111);
    for (int i = 0; i < 20; i++) look({20'h00300 + 20'(i), 12'h0}, 2'd0, 1'b0);
    look(32'h0055_5000, 2'd0, 1'b0);
    look(32'h0055_6000, 2'd0, 1'b0);

    // R5 R6 R7: permission sweep
    phase = "R5";
    for (int p = 0; p < 16; p++) begin
      fill(20'h00777, 22'h0_0777, 4'(p), 3'(p) ^ 3'b101);
      for (int f = 0; f < 2; f++) begin
        fine_rgn = f[0];
        phase = f[0] ? "R7" : "R6";
        for (int a = 0; a < 4; a++)
          for (int u = 0; u < 2; u++) look(32'h0077_7abc, 2'(a), u[0]);
      end
      fine_rgn = 0;
    end

    // R9: single-page flush
    phase = "R9";
    fill(20'h00a01, 22'h0_0a01, 4'b0111, 3'b111);
    fill(20'h00a02, 22'h0_0a02, 4'b0111, 3'b111);
    flush(1'b1, 20'h00a01);
    look(32'h00a0_1000, 2'd0, 1'b0);
    look(32'h00a0_2000, 2'd0, 1'b0);

    // R8 R10: full flush with lookup and refill in the same cycle
    phase = "R10";
    lk_valid = 1; lk_vaddr = 32'h00a0_2000;
    rf_valid = 1; rf_vpn = 20'h00b0b; rf_ppn = 22'h0_0b0b; rf_pte_perm = 4'b0111; rf_rgn_perm = 3'b111;
    flush(1'b0, 20'h0);
    rf_valid = 0; lk_valid = 0;
    phase = "R8";
    look(32'h00a0_2000, 2'd0, 1'b0);
    look(32'h00b0_b000, 2'd0, 1'b0);
    look(32'h0077_7000, 2'd0, 1'b0);
    // R4: freed slots reused before any eviction
    fill(20'h00c00, 22'h0_0c00, 4'b0111, 3'b111);
    look(32'h00c0_0123, 2'd0, 1'b0);
    step();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      total++;
      bad++;
      $display("FAIL watchdog phase=%s actual=%0d expected=<100000", phase, cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule